// File: doc/BRIEF.md
# Variable In-Lane Vector Permute Unit

This block reorders the elements of a 256-bit data vector under the steering of a companion 256-bit control vector. Each output element picks its source from inside the same 128-bit segment. Sources never cross a segment boundary. Two element sizes are supported: 32-bit elements, steered by the two lowest bits of each 32-bit control lane, and 64-bit elements, steered by bit 1 of each 64-bit control lane. The operation can be a full 256-bit operation or a narrow 128-bit operation. In the narrow case the upper segment of the result is cleared.

The unit decodes a small instruction field made of an opcode byte, a width bit and a W bit, alongside its vector operands. A legal request produces a registered result and a one-cycle valid pulse on the following clock. An illegal encoding raises a one-cycle flag and leaves the result register untouched. The unit does not read a register file, fetch memory operands or generate addresses. It sits behind whatever delivers the operands and has no backpressure.

Top module: `vperm_lane_unit`

## Requirements
- R1: With 32-bit elements, result lane k (bits 32k+31..32k) equals data element 4*floor(k/4) + c, where c is bits [1:0] of control lane k; control bits [31:2] of every lane have no effect.
- R2: With 64-bit elements, result lane k (bits 64k+63..64k) equals data element 2*floor(k/2) + b, where b is bit 1 of control lane k (0 picks the lower element, 1 the upper); every other control bit, bit 0 included, has no effect.
- R3: In a 256-bit operation, result bits [255:128] depend only on data and control bits [255:128], and result bits [127:0] depend only on data and control bits [127:0].
- R4: In a 128-bit operation, result bits [127:0] are the permutation of data bits [127:0] under control bits [127:0], and result bits [255:128] are zero.
- R5: Opcode 8'h0C selects 32-bit elements and opcode 8'h0D selects 64-bit elements; the width bit selects 128-bit (0) or 256-bit (1) operation.
- R6: A legal request (valid high, opcode 8'h0C or 8'h0D, W bit 0) drives res_valid high for exactly the next cycle, with res_out updated on that same clock edge.
- R7: A request with valid high and either W bit 1 or any other opcode drives illegal high for exactly the next cycle, with res_valid low in that cycle.
- R8: After an illegal request or an idle cycle, res_out keeps its previous value.
- R9: A cycle with valid low gives res_valid and illegal both low in the next cycle.
- R10: While the synchronous active-high reset is sampled high, res_out, res_valid and illegal are all cleared to zero on the clock edge.

Ports are listed below in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 8 | Operation byte: 8'h0C is 32-bit elements, 8'h0D is 64-bit elements |
| wide | input | 1 | 0: 128-bit operation, 1: 256-bit operation |
| w_bit | input | 1 | Must be 0 for a legal request |
| data_in | input | 256 | Source element vector |
| ctrl_in | input | 256 | Per-lane steering vector |
| res_out | output | 256 | Registered permuted result |
| res_valid | output | 1 | One-cycle pulse for a legal request |
| illegal | output | 1 | One-cycle pulse for an illegal encoding |

## Verification
The hardest behaviour to reach from the ports is the ignoring of control bits. Random control vectors almost always set the selector bits together with the surrounding bits, so a design that decoded the wrong bit could still match by chance. The stimulus therefore includes directed requests in which every ignored control bit is one, including bit 0 of each 64-bit lane, while the selector bits walk through every value. The narrow and wide forms are also given the same low operands with different upper operands, to show that nothing leaks between segments.

// File: rtl/vpm_pkg.sv
package vpm_pkg;

  localparam logic [7:0] OPC_SEL32 = 8'h0C;
  localparam logic [7:0] OPC_SEL64 = 8'h0D;

  typedef enum logic {
    ELEM_32 = 1'b0,
    ELEM_64 = 1'b1
  } elem_mode_e;

endpackage

// File: rtl/vpm_decode.sv
module vpm_decode
  import vpm_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic       w_bit,
  output logic       legal,
  output elem_mode_e mode
);

  logic is32, is64;

  always_comb begin
    is32  = (opcode == OPC_SEL32);
    is64  = (opcode == OPC_SEL64);
    legal = (is32 | is64) & ~w_bit;
    mode  = is64 ? ELEM_64 : ELEM_32;
  end

endmodule

// File: rtl/vpm_seg_perm.sv
module vpm_seg_perm
  import vpm_pkg::*;
#(
  parameter int SEG_W = 128
) (
  input  logic [SEG_W-1:0] seg_data,
  input  logic [SEG_W-1:0] seg_ctrl,
  input  elem_mode_e       mode,
  output logic [SEG_W-1:0] seg_out
);

  localparam int N32 = SEG_W / 32;
  localparam int N64 = SEG_W / 64;
  localparam int S32 = $clog2(N32);
  localparam int S64 = $clog2(N64);

  logic [31:0]      d32 [N32];
  logic [63:0]      d64 [N64];
  logic [SEG_W-1:0] r32;
  logic [SEG_W-1:0] r64;

  // 32-bit element lanes: selector sits at the bottom of each control lane
  for (genvar i = 0; i < N32; i++) begin : g_lane32
    logic [S32-1:0] sel;
    assign d32[i]         = seg_data[i*32 +: 32];
    assign sel            = seg_ctrl[i*32 +: S32];
    assign r32[i*32 +: 32] = d32[sel];
  end

  // 64-bit element lanes: selector starts at bit 1 of each control lane
  for (genvar j = 0; j < N64; j++) begin : g_lane64
    logic [S64-1:0] sel;
    assign d64[j]          = seg_data[j*64 +: 64];
    assign sel             = seg_ctrl[j*64 + 1 +: S64];
    assign r64[j*64 +: 64] = d64[sel];
  end

  always_comb seg_out = (mode == ELEM_64) ? r64 : r32;

endmodule

// File: rtl/vperm_lane_unit.sv
module vperm_lane_unit
  import vpm_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int SEG_W  = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        opcode,
  input  logic              wide,
  input  logic              w_bit,
  input  logic [DATA_W-1:0] data_in,
  input  logic [DATA_W-1:0] ctrl_in,
  output logic [DATA_W-1:0] res_out,
  output logic              res_valid,
  output logic              illegal
);

  localparam int N_SEG = DATA_W / SEG_W;

  logic              legal;
  elem_mode_e        mode;
  logic [DATA_W-1:0] perm;
  logic [DATA_W-1:0] masked;

  vpm_decode u_dec (
    .opcode (opcode),
    .w_bit  (w_bit),
    .legal  (legal),
    .mode   (mode)
  );

  for (genvar s = 0; s < N_SEG; s++) begin : g_seg
    vpm_seg_perm #(.SEG_W(SEG_W)) u_seg (
      .seg_data (data_in[s*SEG_W +: SEG_W]),
      .seg_ctrl (ctrl_in[s*SEG_W +: SEG_W]),
      .mode     (mode),
      .seg_out  (perm[s*SEG_W +: SEG_W])
    );
    // narrow operations keep only the lowest segment
    if (s == 0) begin : g_keep
      assign masked[s*SEG_W +: SEG_W] = perm[s*SEG_W +: SEG_W];
    end else begin : g_mask
      assign masked[s*SEG_W +: SEG_W] = wide ? perm[s*SEG_W +: SEG_W] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out   <= '0;
      res_valid <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      res_valid <= in_valid & legal;
      illegal   <= in_valid & ~legal;
      if (in_valid && legal) res_out <= masked;
    end
  end

endmodule

// File: rtl/vpm_checker.sv
module vpm_checker #(
  parameter int DATA_W = 256,
  parameter int SEG_W  = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [7:0]        opcode,
  input logic              wide,
  input logic              w_bit,
  input logic [DATA_W-1:0] res_out,
  input logic              res_valid,
  input logic              illegal
);

  logic known_op;
  assign known_op = (opcode == 8'h0C) || (opcode == 8'h0D);

  a_r6_valid_next: assert property (@(posedge clk) disable iff (rst)
    (in_valid && known_op && !w_bit) |=> (res_valid && !illegal));

  a_r7_illegal_flag: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (w_bit || !known_op)) |=> (illegal && !res_valid));

  a_r8_hold_on_illegal: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (w_bit || !known_op)) |=> $stable(res_out));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!res_valid && !illegal && $stable(res_out)));

  a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && known_op && !w_bit && !wide) |=> (res_out[DATA_W-1:SEG_W] == '0));

  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(res_valid && illegal));

endmodule

bind vperm_lane_unit vpm_checker #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .opcode    (opcode),
  .wide      (wide),
  .w_bit     (w_bit),
  .res_out   (res_out),
  .res_valid (res_valid),
  .illegal   (illegal)
);

// File: tb/sim_vperm_lane_unit.sv
module sim_vperm_lane_unit;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 20000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [7:0]   opcode = 8'h00;
  logic         wide = 1'b0;
  logic         w_bit = 1'b0;
  logic [255:0] data_in = '0;
  logic [255:0] ctrl_in = '0;
  logic [255:0] res_out;
  logic         res_valid;
  logic         illegal;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  string cur_tag = "R6";

  logic [255:0] exp_res = '0;
  logic         exp_val = 1'b0;
  logic         exp_ill = 1'b0;
  string        exp_tag = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  vperm_lane_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode), .wide(wide),
    .w_bit(w_bit), .data_in(data_in), .ctrl_in(ctrl_in), .res_out(res_out),
    .res_valid(res_valid), .illegal(illegal)
  );

  function automatic logic [255:0] ref_perm(input logic [255:0] d, input logic [255:0] c,
                                            input logic is64, input logic wd);
    logic [255:0] r = '0;
    if (!is64) begin
      for (int e = 0; e < 8; e++) begin
        int src = (e / 4) * 4 + int'(c[e*32 +: 2]);
        r[e*32 +: 32] = d[src*32 +: 32];
      end
    end else begin
      for (int e = 0; e < 4; e++) begin
        int src = (e / 2) * 2 + int'(c[e*64 + 1]);
        r[e*64 +: 64] = d[src*64 +: 64];
      end
    end
    if (!wd) r[255:128] = '0;
    return r;
  endfunction

  // behavioural model, updated on every edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      exp_res <= '0; exp_val <= 1'b0; exp_ill <= 1'b0; exp_tag <= "R10";
    end else if (!in_valid) begin
      exp_val <= 1'b0; exp_ill <= 1'b0; exp_tag <= "R9 R8";
    end else if (w_bit || (opcode != 8'h0C && opcode != 8'h0D)) begin
      exp_val <= 1'b0; exp_ill <= 1'b1; exp_tag <= "R7 R8";
    end else begin
      exp_res <= ref_perm(data_in, ctrl_in, opcode == 8'h0D, wide);
      exp_val <= 1'b1; exp_ill <= 1'b0; exp_tag <= cur_tag;
    end
  end

  // compare away from the active edge, every cycle
  always @(negedge clk) begin
    if (cyc > 0) begin
      n_tests++;
      if (res_out !== exp_res || res_valid !== exp_val || illegal !== exp_ill) begin
        n_fail++;
        $display("FAIL %s: res=%h v=%b ill=%b expected res=%h v=%b ill=%b",
                 exp_tag, res_out, res_valid, illegal, exp_res, exp_val, exp_ill);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > MAX_CYC) begin
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, MAX_CYC);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [255:0] rand256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic issue(input logic v, input logic [7:0] op, input logic wd, input logic w,
                       input logic [255:0] d, input logic [255:0] c, input string tag);
    @(negedge clk);
    in_valid = v; opcode = op; wide = wd; w_bit = w;
    data_in = d; ctrl_in = c; cur_tag = tag;
  endtask

  initial begin
    logic [255:0] d, c, hi;
    repeat (3) @(negedge clk);   // R10 checked while reset is held
    @(negedge clk); rst = 1'b0;

    // R1 R5: selector sweep with every ignored bit of 32-bit lanes set
    for (int s = 0; s < 4; s++) begin
      d = rand256();
      for (int e = 0; e < 8; e++) c[e*32 +: 32] = 32'hFFFF_FFFC | 32'((s + e) % 4);
      issue(1'b1, 8'h0C, 1'b1, 1'b0, d, c, "R1 R5");
    end
    // R2 R5: 64-bit lanes, all bits but bit 1 set, bit 0 included
    for (int s = 0; s < 4; s++) begin
      d = rand256();
      for (int e = 0; e < 4; e++) c[e*64 +: 64] = ~64'h2 | (64'((s >> (e % 2)) & 1) << 1);
      issue(1'b1, 8'h0D, 1'b1, 1'b0, d, c, "R2 R5");
    end
    // R3 R4: same low operands, different upper operands, wide and narrow
    d = rand256(); c = rand256();
    for (int k = 0; k < 3; k++) begin
      hi = rand256();
      issue(1'b1, 8'h0C, 1'b1, 1'b0, {hi[255:128], d[127:0]}, {hi[127:0], c[127:0]}, "R3");
      issue(1'b1, 8'h0C, 1'b0, 1'b0, {hi[255:128], d[127:0]}, {hi[127:0], c[127:0]}, "R4");
      issue(1'b1, 8'h0D, 1'b0, 1'b0, {hi[255:128], d[127:0]}, {hi[127:0], c[127:0]}, "R4");
    end
    // R7 R8: illegal encodings between legal ones
    issue(1'b1, 8'h0C, 1'b1, 1'b1, rand256(), rand256(), "R7");
    issue(1'b1, 8'h0E, 1'b1, 1'b0, rand256(), rand256(), "R7");
    issue(1'b1, 8'h0B, 1'b0, 1'b0, rand256(), rand256(), "R7");
    issue(1'b1, 8'h0D, 1'b0, 1'b1, rand256(), rand256(), "R7");
    // R9: idle with changing operands
    issue(1'b0, 8'h0C, 1'b1, 1'b0, rand256(), rand256(), "R9");
    issue(1'b0, 8'h0D, 1'b1, 1'b0, rand256(), rand256(), "R9");
    // R6: back-to-back random traffic, mixed with idle and illegal
    for (int k = 0; k < 400; k++) begin
      int p = $urandom_range(0, 9);
      logic [7:0] op = (p < 4) ? 8'h0C : (p < 8) ? 8'h0D : 8'($urandom);
      issue(($urandom_range(0, 7) != 0), op, 1'($urandom), ($urandom_range(0, 9) == 0),
            rand256(), rand256(), "R6");
    end
    // R10: reset mid-stream after a result is held
    issue(1'b1, 8'h0C, 1'b1, 1'b0, rand256(), rand256(), "R6");
    @(negedge clk); rst = 1'b1; in_valid = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule